// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Edge and Level Interrupts

This block is a 32-pin general-purpose I/O controller behind a small 32-bit register bus. Each pin has these controls: an input enable, an output enable, an output value with a separate inversion mask, and a pull-up enable. The block works out each pin's pad level on every clock. An external driver on the pin takes priority. If there is none, the internal output is used when the output enable is set. If neither applies, the pull-up enable bit sets the level. The input enable gates the pad level, and the result is stored as the pin's sampled value.

Four sticky pending sources watch each pin's sampled value: rising edge, falling edge, high level and low level. Each source has its own enable mask. Writing a 1 to a pending bit clears it. Each pin raises its own interrupt line whenever an enabled source of that pin is pending. The block also flags a short on any pin that is driven from outside while its output enable is set. The drive-strength register and the two alternate-function registers only store values and have no effect on behaviour.

A request is one cycle long: valid, write, a byte address and write data. Read data appears on the cycle after a read request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: All offsets are aligned word addresses. The read/write registers sit at 0x04 input enable, 0x08 output enable, 0x0C output value, 0x10 pull enable, 0x14 drive strength, 0x18 rise enable, 0x20 fall enable, 0x28 high enable, 0x30 low enable, 0x38 alt-function enable, 0x3C alt-function select and 0x40 output inversion. Each reads back its last written value, and read data is valid on the cycle after the request.
- R2: Pad level per pin follows a priority order. ext_value is used when ext_drive_en is 1. Otherwise the internal drive is used when the output enable is 1. Otherwise the pull enable bit is used.
- R3: The internal drive of a pin is its output value bit XOR its inversion bit.
- R4: short_flag bit n is 1 exactly when ext_drive_en bit n and output enable bit n are both 1.
- R5: The register at 0x00 returns input enable AND pad level, sampled on each clock. Writes to it are ignored.
- R6: The rise pending register (0x1C) sets a bit when the sampled value goes from 0 to 1 against the previously stored sample. The fall pending register (0x24) sets a bit on a change from 1 to 0. Both bits stay set until cleared.
- R7: The high pending register (0x2C) sets a bit on every clock where the sampled value is 1. The low pending register (0x34) sets a bit on every clock where it is 0. Both are sticky, and a cleared bit sets again when its condition still holds.
- R8: Writing to a pending register clears exactly the bits written as 1 and leaves the others unchanged.
- R9: irq bit n is the OR over the four sources of (pending AND enable) for pin n.
- R10: Reset clears every register, the stored sample and the read data.
- R11: Reads of unmapped or misaligned offsets return 0. Writes to them change no register.
- R12: Drive strength and the alt-function registers have no effect on pad_level, short_flag or irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address in the 0x100 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ext_drive_en | input | 32 | Per-pin: an external device drives the pad |
| ext_value | input | 32 | Per-pin externally driven level |
| pad_level | output | 32 | Resolved pad level |
| short_flag | output | 32 | Per-pin external-versus-internal drive conflict |
| irq | output | 32 | Per-pin interrupt |

## Verification
The bench goes after the pad priority: a design that let the output enable win over an external driver would put the internal value on contended pins and miss the short. Edge tests compare against the stored sample and not the raw pad. With the input enable off, toggling the external driver must leave rise pending clear, and a design that edges on the raw pad would set it. Write-1-to-clear is checked with a mask that covers only some bits, so a design that clears a whole register fails. A level bit must come back right after it is cleared while its condition holds, and a design that lost that re-set would read 0. Writes to the value register and to unmapped offsets must leave the read-back state unchanged.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] ext_drive_en,
  input  logic [PINS-1:0] ext_value,
  output logic [PINS-1:0] pad_level,
  output logic [PINS-1:0] short_flag,
  output logic [PINS-1:0] irq
);
  localparam logic [AW-1:0] A_VAL   = AW'('h00);
  localparam logic [AW-1:0] A_IEN   = AW'('h04);
  localparam logic [AW-1:0] A_OEN   = AW'('h08);
  localparam logic [AW-1:0] A_OUT   = AW'('h0C);
  localparam logic [AW-1:0] A_PULL  = AW'('h10);
  localparam logic [AW-1:0] A_DRV   = AW'('h14);
  localparam logic [AW-1:0] A_RE    = AW'('h18);
  localparam logic [AW-1:0] A_RP    = AW'('h1C);
  localparam logic [AW-1:0] A_FE    = AW'('h20);
  localparam logic [AW-1:0] A_FP    = AW'('h24);
  localparam logic [AW-1:0] A_HE    = AW'('h28);
  localparam logic [AW-1:0] A_HP    = AW'('h2C);
  localparam logic [AW-1:0] A_LE    = AW'('h30);
  localparam logic [AW-1:0] A_LP    = AW'('h34);
  localparam logic [AW-1:0] A_AFEN  = AW'('h38);
  localparam logic [AW-1:0] A_AFSEL = AW'('h3C);
  localparam logic [AW-1:0] A_INV   = AW'('h40);
  localparam logic [PINS-1:0] ZERO  = '0;

  logic [PINS-1:0] in_en, out_en, out_val, pull_en, drv, af_en, af_sel, inv;
  logic [PINS-1:0] rise_en, fall_en, high_en, low_en;
  logic [PINS-1:0] rise_p, fall_p, high_p, low_p;
  logic [PINS-1:0] stored, samp, int_drive, rd_mux;
  logic            wr;

  assign wr         = bus_valid & bus_write;
  assign int_drive  = out_val ^ inv;
  assign pad_level  = (ext_drive_en & ext_value)
                    | (~ext_drive_en & out_en & int_drive)
                    | (~ext_drive_en & ~out_en & pull_en);
  assign short_flag = ext_drive_en & out_en;
  assign samp       = in_en & pad_level;
  assign irq        = (rise_p & rise_en) | (fall_p & fall_en)
                    | (high_p & high_en) | (low_p & low_en);

  function automatic logic [PINS-1:0] clr_mask(input logic [AW-1:0] a);
    return (wr && bus_addr == a) ? bus_wdata : ZERO;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_en <= '0; out_en <= '0; out_val <= '0; pull_en <= '0;
      drv <= '0; af_en <= '0; af_sel <= '0; inv <= '0;
      rise_en <= '0; fall_en <= '0; high_en <= '0; low_en <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_IEN:   in_en   <= bus_wdata;
        A_OEN:   out_en  <= bus_wdata;
        A_OUT:   out_val <= bus_wdata;
        A_PULL:  pull_en <= bus_wdata;
        A_DRV:   drv     <= bus_wdata;
        A_RE:    rise_en <= bus_wdata;
        A_FE:    fall_en <= bus_wdata;
        A_HE:    high_en <= bus_wdata;
        A_LE:    low_en  <= bus_wdata;
        A_AFEN:  af_en   <= bus_wdata;
        A_AFSEL: af_sel  <= bus_wdata;
        A_INV:   inv     <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored <= '0;
      rise_p <= '0; fall_p <= '0; high_p <= '0; low_p <= '0;
    end else begin
      stored <= samp;
      rise_p <= (rise_p & ~clr_mask(A_RP)) | (samp & ~stored);
      fall_p <= (fall_p & ~clr_mask(A_FP)) | (~samp & stored);
      high_p <= (high_p & ~clr_mask(A_HP)) | samp;
      low_p  <= (low_p  & ~clr_mask(A_LP)) | ~samp;
    end
  end

  always_comb begin
    case (bus_addr)
      A_VAL:   rd_mux = stored;
      A_IEN:   rd_mux = in_en;
      A_OEN:   rd_mux = out_en;
      A_OUT:   rd_mux = out_val;
      A_PULL:  rd_mux = pull_en;
      A_DRV:   rd_mux = drv;
      A_RE:    rd_mux = rise_en;
      A_RP:    rd_mux = rise_p;
      A_FE:    rd_mux = fall_en;
      A_FP:    rd_mux = fall_p;
      A_HE:    rd_mux = high_en;
      A_HP:    rd_mux = high_p;
      A_LE:    rd_mux = low_en;
      A_LP:    rd_mux = low_p;
      A_AFEN:  rd_mux = af_en;
      A_AFSEL: rd_mux = af_sel;
      A_INV:   rd_mux = inv;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (bus_valid && !bus_write) ? rd_mux : '0;
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic [PINS-1:0] ext_drive_en,
  input logic [PINS-1:0] ext_value,
  input logic [PINS-1:0] pad_level,
  input logic [PINS-1:0] short_flag,
  input logic [PINS-1:0] irq,
  input logic [PINS-1:0] rise_p,
  input logic [PINS-1:0] fall_p,
  input logic [PINS-1:0] high_p,
  input logic [PINS-1:0] low_p,
  input logic [PINS-1:0] samp
);
  localparam logic [AW-1:0] A_RP = AW'('h1C);

  assert_ext_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_level ^ ext_value) & ext_drive_en) == '0);

  assert_short_needs_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (short_flag & ~ext_drive_en) == '0);

  assert_rise_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == A_RP) |=> (($past(rise_p) & ~rise_p) == '0));

  assert_high_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(samp) & ~high_p) == '0));

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(rise_p | fall_p | high_p | low_p)) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .ext_drive_en(ext_drive_en), .ext_value(ext_value),
  .pad_level(pad_level), .short_flag(short_flag), .irq(irq),
  .rise_p(rise_p), .fall_p(fall_p), .high_p(high_p), .low_p(low_p), .samp(samp));

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] ext_drive_en = '0, ext_value = '0;
  logic [31:0] pad_level, short_flag, irq;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_drive_en(ext_drive_en), .ext_value(ext_value), .pad_level(pad_level),
    .short_flag(short_flag), .irq(irq));

  // fields: ext_en, ext_val, oe, out, inv, pull, ien, exp_pad, exp_short, exp_val
  localparam logic [31:0] VEC [4][10] = '{
    '{32'hF0, 32'hA0, 32'h3C, 32'h0F, 32'h05, 32'hC3, 32'hFFFFFFFF, 32'hAB, 32'h30, 32'hAB},
    '{32'h00, 32'hFF, 32'hFF, 32'h55, 32'hFF, 32'h00, 32'hFFFFFFFF, 32'hAA, 32'h00, 32'hAA},
    '{32'hFF, 32'h5A, 32'h00, 32'h33, 32'h00, 32'hFF, 32'h0F,       32'h5A, 32'h00, 32'h0A},
    '{32'h00, 32'h00, 32'h00, 32'hFF, 32'h00, 32'h81, 32'h00,       32'h81, 32'h00, 32'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, p;
    idle(3);
    check("R10 rdata in reset", bus_rdata, 0);
    check("R10 pad in reset", pad_level, 0);
    check("R10 irq in reset", irq, 0);
    rst_n = 1;
    rd(8'h08, d); check("R10 output enable zero", d, 0);
    rd(8'h18, d); check("R10 rise enable zero", d, 0);

    for (int v = 0; v < 4; v++) begin
      @(negedge clk); ext_drive_en = VEC[v][0]; ext_value = VEC[v][1];
      wr(8'h08, VEC[v][2]); wr(8'h0C, VEC[v][3]); wr(8'h40, VEC[v][4]);
      wr(8'h10, VEC[v][5]); wr(8'h04, VEC[v][6]);
      idle(1);
      check("R2 R3 pad level", pad_level, VEC[v][7]);
      check("R4 short flag", short_flag, VEC[v][8]);
      rd(8'h00, d); check("R5 sampled value", d, VEC[v][9]);
    end

    wr(8'h40, 32'h1357_9BDF); rd(8'h40, d); check("R1 inversion readback", d, 32'h1357_9BDF);
    wr(8'h0C, 32'h2468_ACE0); rd(8'h0C, d); check("R1 output readback", d, 32'h2468_ACE0);

    // edge and level setup: pin 0 externally driven low, input enabled
    wr(8'h08, 0); wr(8'h10, 0); wr(8'h40, 0);
    @(negedge clk); ext_drive_en = 32'h1; ext_value = 0;
    wr(8'h04, 32'h1); idle(2);
    wr(8'h1C, '1); wr(8'h24, '1); wr(8'h2C, '1);
    rd(8'h1C, d); check("R8 rise cleared", d, 0);
    rd(8'h24, d); check("R8 fall cleared", d, 0);
    @(negedge clk); ext_value = 32'h1; idle(2);
    rd(8'h1C, d); check("R6 rise set", d, 32'h1);
    rd(8'h24, d); check("R6 no fall on rise", d, 0);
    @(negedge clk); ext_value = 0; idle(2);
    rd(8'h24, d); check("R6 fall set", d, 32'h1);
    rd(8'h1C, d); check("R6 rise sticky", d, 32'h1);
    rd(8'h2C, d); check("R7 high sticky while low", d, 32'h1);
    wr(8'h2C, 32'h2); rd(8'h2C, d); check("R8 high unaffected by other bit", d, 32'h1);
    wr(8'h2C, 32'h1); rd(8'h2C, d); check("R8 high cleared", d, 0);
    wr(8'h34, 32'h1); rd(8'h34, d); check("R7 low re-sets", d[0], 1'b1);

    // input disabled: toggling must not produce an edge
    wr(8'h04, 0); wr(8'h1C, '1); idle(1);
    @(negedge clk); ext_value = 32'h1; idle(2);
    rd(8'h1C, d); check("R6 R5 masked input no rise", d, 0);

    // interrupts
    @(negedge clk); ext_value = 0;
    wr(8'h04, 32'h1); wr(8'h18, 32'h1); wr(8'h1C, '1); idle(1);
    check("R9 irq idle", irq, 0);
    @(negedge clk); ext_value = 32'h1; idle(2);
    check("R9 irq on rise", irq, 32'h1);
    wr(8'h1C, 32'h1); idle(1);
    check("R9 irq after clear", irq, 0);
    wr(8'h30, 32'hFFFF_FFFE); idle(1);
    check("R9 irq from low level", irq, 32'hFFFF_FFFE);
    wr(8'h30, 0);

    // value register ignores writes
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R5 value write ignored", d, 32'h1);

    // unmapped
    wr(8'h08, 32'h0000_1230);
    wr(8'h80, 32'hFFFF_FFFF); wr(8'h0A, 32'hFFFF_FFFF);
    rd(8'h80, d); check("R11 unmapped read", d, 0);
    rd(8'h44, d); check("R11 unmapped read 0x44", d, 0);
    rd(8'h08, d); check("R11 write no effect", d, 32'h0000_1230);

    // storage-only registers
    @(negedge clk); p = pad_level;
    wr(8'h14, 32'hDEAD_BEEF); wr(8'h38, 32'hFFFF_FFFF); wr(8'h3C, 32'hA5A5_A5A5);
    rd(8'h14, d); check("R1 drive readback", d, 32'hDEAD_BEEF);
    rd(8'h38, d); check("R1 afen readback", d, 32'hFFFF_FFFF);
    rd(8'h3C, d); check("R1 afsel readback", d, 32'hA5A5_A5A5);
    check("R12 pad unchanged", pad_level, p);
    check("R12 short unchanged", short_flag, 32'h0);
    check("R12 irq unchanged", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule